// File: doc/BRIEF.md
# Rotating-Window Integer Register File

This block is the integer register file of a 32-bit processor whose architectural registers are seen through a sliding window. Eight global registers are shared by all code. Behind them sits a ring of windows, each with its own eight locals and eight outgoing registers. The incoming registers of one window are the same physical storage as the outgoing registers of the window that follows it on the ring. A pointer register selects the active window, and a mask register marks the windows that software has not yet made available. The execute stage reads two operands and writes one result by 5-bit architectural register number. It also issues window-advance (save) and window-retreat (restore) operations. For these operations the block adds the two operands, moves the pointer, and writes the sum into the destination register as seen from the new window. When the target window is marked in the mask, the operation is dropped and a one-cycle trap flag is raised for the trap logic outside.

A status path reads and writes the window pointer, a 4-bit interrupt level and a supervisor bit. It flags an attempt to select a window that does not exist. A small program counter pair is also kept and is initialised at reset. The controller is a four-state machine: `ST_RUN` (normal), `ST_OVF` (save blocked last cycle), `ST_UNF` (restore blocked last cycle) and `ST_BADCWP` (illegal pointer write last cycle). Each trap state lasts exactly one cycle. On every clock edge, from any state, the machine takes one of the following transitions, checked in this order:

- An illegal status write goes to `ST_BADCWP`.
- A blocked save goes to `ST_OVF`.
- A blocked restore goes to `ST_UNF`.
- Anything else returns to `ST_RUN`.

Top module: `regwin_file`

## Requirements
- R1: Reset clears every register, sets the window pointer to 0, sets the mask to binary 10 (only window 1 unavailable), sets the status read to 0x080 (supervisor bit set, level 0), and sets the program counter pair to 0 and 4.
- R2: Register numbers 0–7 select globals, 8–15 the current window's outs, 16–23 its locals and 24–31 its ins. The ins of window w are the outs of window (w+1) mod NWIN.
- R3: Operation code 01 (save) moves the pointer to (pointer − 1) mod NWIN on the next edge. Codes 00 and 11 do nothing.
- R4: Operation code 10 (restore) moves the pointer to (pointer + 1) mod NWIN on the next edge.
- R5: A save or restore writes port-A data plus either port-B data or the sign-extended 13-bit immediate (chosen by `imm_sel`) into register `op_dst` of the new window. The operands are read in the old window.
- R6: A save whose target window has its mask bit set raises `trap_ovf` for one cycle. The pointer and all registers stay unchanged.
- R7: A restore whose target window has its mask bit set raises `trap_unf` for one cycle. The pointer and all registers stay unchanged.
- R8: Register 0 always reads zero. Writes to it, from the write port or as a save/restore destination, have no effect.
- R9: The status read returns the pointer in bits 4:0, the supervisor bit in bit 7 and the interrupt level in bits 11:8. A status write loads all three from the same positions.
- R10: A status write with bits 4:0 at or above NWIN raises `cwp_err` for one cycle and leaves the whole status unchanged.
- R11: A status write in the same cycle as a save or restore takes priority. The operation is dropped: no pointer step, no destination write, no trap.
- R12: The write port addresses through the pointer as it stands before the edge. If it hits the same physical word as a save/restore destination in the same cycle, the save/restore value is stored.
- R13: Each `pc_step` pulse loads the program counter from the next-PC and advances the next-PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 5 | Read port A register number |
| rd_a_data | output | 32 | Read port A data (combinational) |
| rd_b_idx | input | 5 | Read port B register number |
| rd_b_data | output | 32 | Read port B data (combinational) |
| wr_en | input | 1 | Write port enable |
| wr_idx | input | 5 | Write port register number |
| wr_data | input | 32 | Write port data |
| op | input | 2 | 00 none, 01 save, 10 restore, 11 none |
| imm_sel | input | 1 | Use immediate instead of port B for the sum |
| imm | input | 13 | Signed immediate operand |
| op_dst | input | 5 | Destination register number in the new window |
| wim_wr | input | 1 | Load the window mask |
| wim_wdata | input | NWIN | New window mask |
| sr_wr | input | 1 | Status write strobe |
| sr_wdata | input | 32 | Status write data |
| sr_rdata | output | 32 | Status read data |
| pc_step | input | 1 | Advance the program counter pair |
| pc | output | 32 | Program counter |
| npc | output | 32 | Next program counter |
| trap_ovf | output | 1 | Window overflow flag |
| trap_unf | output | 1 | Window underflow flag |
| cwp_err | output | 1 | Illegal pointer write flag |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a status write together with a save. The bench drives both on one edge and then requires the written pointer value, an untouched destination global and no trap flag. The second pair is a write-port store together with a save destination that resolves to the same physical word (an out of the old window, named as an in of the new one). The bench returns to the old window afterwards and requires the save's sum to be read there, not the write-port value.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

    typedef enum logic [1:0] {
        OP_NONE    = 2'b00,
        OP_SAVE    = 2'b01,
        OP_RESTORE = 2'b10,
        OP_RSVD    = 2'b11
    } win_op_e;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_OVF    = 2'd1,
        ST_UNF    = 2'd2,
        ST_BADCWP = 2'd3
    } ctrl_state_e;

    localparam int XLEN      = 32;
    localparam int IDX_W     = 5;
    localparam int CWP_FLD_W = 5;
    localparam int PIL_LSB   = 8;
    localparam int SUP_BIT   = 7;

endpackage

// File: rtl/regwin_map.sv
module regwin_map #(
    parameter int NWIN = 8,
    parameter int CW   = $clog2(NWIN),
    parameter int PW   = $clog2(8 + 16 * NWIN)
) (
    input  logic [CW-1:0] cwp,
    input  logic [4:0]    idx,
    output logic [PW-1:0] phys
);
    logic [CW-1:0] win_sel;
    logic [PW-1:0] base;

    always_comb begin
        if (idx[4:3] == 2'b11) begin
            win_sel = (cwp == CW'(NWIN - 1)) ? '0 : cwp + CW'(1);
        end else begin
            win_sel = cwp;
        end
        base = PW'(8) + (PW'(win_sel) << 4);
        unique case (idx[4:3])
            2'b00:   phys = PW'(idx[2:0]);
            2'b01:   phys = base + PW'(idx[2:0]);
            2'b10:   phys = base + PW'(8) + PW'(idx[2:0]);
            default: phys = base + PW'(idx[2:0]);
        endcase
    end
endmodule

// File: rtl/regwin_store.sv
module regwin_store #(
    parameter int DW    = 32,
    parameter int DEPTH = 136,
    parameter int PW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] ra_addr,
    output logic [DW-1:0] ra_data,
    input  logic [PW-1:0] rb_addr,
    output logic [DW-1:0] rb_data,
    input  logic          wp_en,
    input  logic [PW-1:0] wp_addr,
    input  logic [DW-1:0] wp_data,
    input  logic          ws_en,
    input  logic [PW-1:0] ws_addr,
    input  logic [DW-1:0] ws_data
);
    logic [DW-1:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[g] <= '0;
            end else if (ws_en && ws_addr == PW'(g)) begin
                mem[g] <= ws_data;
            end else if (wp_en && wp_addr == PW'(g)) begin
                mem[g] <= wp_data;
            end
        end
    end

    assign ra_data = (ra_addr == '0) ? '0 : mem[ra_addr];
    assign rb_data = (rb_addr == '0) ? '0 : mem[rb_addr];
endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
    import regwin_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int CW   = $clog2(NWIN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      op,
    input  logic            sr_wr,
    input  logic [31:0]     sr_wdata,
    input  logic            wim_wr,
    input  logic [NWIN-1:0] wim_wdata,
    input  logic            pc_step,
    output logic [CW-1:0]   cwp_q,
    output logic [CW-1:0]   dest_cwp,
    output logic            op_go,
    output logic [NWIN-1:0] wim_q,
    output logic [31:0]     sr_rdata,
    output logic [31:0]     pc,
    output logic [31:0]     npc,
    output logic            trap_ovf,
    output logic            trap_unf,
    output logic            cwp_err
);
    ctrl_state_e   state_q, state_d;
    win_op_e       op_e;
    logic [CW-1:0] cwp_dn, cwp_up;
    logic          is_save, is_rest, blocked, sr_bad;
    logic [3:0]    pil_q;
    logic          sup_q;

    always_comb begin
        op_e     = win_op_e'(op);
        is_save  = (op_e == OP_SAVE);
        is_rest  = (op_e == OP_RESTORE);
        cwp_dn   = (cwp_q == '0) ? CW'(NWIN - 1) : cwp_q - CW'(1);
        cwp_up   = (cwp_q == CW'(NWIN - 1)) ? '0 : cwp_q + CW'(1);
        dest_cwp = is_save ? cwp_dn : cwp_up;
        blocked  = wim_q[dest_cwp];
        sr_bad   = sr_wr && (sr_wdata[CWP_FLD_W-1:0] >= CWP_FLD_W'(NWIN));
        op_go    = (is_save || is_rest) && !sr_wr && !blocked;
    end

    // next-state logic: every state is left after one cycle
    always_comb begin
        state_d = ST_RUN;
        unique case (state_q)
            ST_RUN, ST_OVF, ST_UNF, ST_BADCWP: begin
                if (sr_bad)                        state_d = ST_BADCWP;
                else if (is_save && !sr_wr && blocked) state_d = ST_OVF;
                else if (is_rest && !sr_wr && blocked) state_d = ST_UNF;
                else                               state_d = ST_RUN;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // outputs decoded from state
    always_comb begin
        trap_ovf = 1'b0;
        trap_unf = 1'b0;
        cwp_err  = 1'b0;
        unique case (state_q)
            ST_RUN:    ;
            ST_OVF:    trap_ovf = 1'b1;
            ST_UNF:    trap_unf = 1'b1;
            ST_BADCWP: cwp_err  = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cwp_q <= '0;
            wim_q <= NWIN'(2);
            pil_q <= '0;
            sup_q <= 1'b1;
            pc    <= 32'd0;
            npc   <= 32'd4;
        end else begin
            if (sr_wr && !sr_bad) begin
                cwp_q <= sr_wdata[CW-1:0];
                pil_q <= sr_wdata[PIL_LSB +: 4];
                sup_q <= sr_wdata[SUP_BIT];
            end else if (op_go) begin
                cwp_q <= dest_cwp;
            end
            if (wim_wr) wim_q <= wim_wdata;
            if (pc_step) begin
                pc  <= npc;
                npc <= npc + 32'd4;
            end
        end
    end

    always_comb begin
        sr_rdata = '0;
        sr_rdata[CW-1:0]         = cwp_q;
        sr_rdata[SUP_BIT]        = sup_q;
        sr_rdata[PIL_LSB +: 4]   = pil_q;
    end
endmodule

// File: rtl/regwin_file.sv
module regwin_file
    import regwin_pkg::*;
#(
    parameter int NWIN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [4:0]      rd_a_idx,
    output logic [31:0]     rd_a_data,
    input  logic [4:0]      rd_b_idx,
    output logic [31:0]     rd_b_data,
    input  logic            wr_en,
    input  logic [4:0]      wr_idx,
    input  logic [31:0]     wr_data,
    input  logic [1:0]      op,
    input  logic            imm_sel,
    input  logic [12:0]     imm,
    input  logic [4:0]      op_dst,
    input  logic            wim_wr,
    input  logic [NWIN-1:0] wim_wdata,
    input  logic            sr_wr,
    input  logic [31:0]     sr_wdata,
    output logic [31:0]     sr_rdata,
    input  logic            pc_step,
    output logic [31:0]     pc,
    output logic [31:0]     npc,
    output logic            trap_ovf,
    output logic            trap_unf,
    output logic            cwp_err
);
    localparam int CW    = $clog2(NWIN);
    localparam int DEPTH = 8 + 16 * NWIN;
    localparam int PW    = $clog2(DEPTH);
    localparam int NMAP  = 4;

    logic [CW-1:0]   cwp_q, dest_cwp;
    logic [NWIN-1:0] wim_q;
    logic            op_go;
    logic [4:0]      map_idx  [NMAP];
    logic [CW-1:0]   map_cwp  [NMAP];
    logic [PW-1:0]   map_phys [NMAP];
    logic [31:0]     operand_b, sum;

    regwin_ctrl #(.NWIN(NWIN)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .op(op), .sr_wr(sr_wr), .sr_wdata(sr_wdata),
        .wim_wr(wim_wr), .wim_wdata(wim_wdata), .pc_step(pc_step),
        .cwp_q(cwp_q), .dest_cwp(dest_cwp), .op_go(op_go), .wim_q(wim_q),
        .sr_rdata(sr_rdata), .pc(pc), .npc(npc),
        .trap_ovf(trap_ovf), .trap_unf(trap_unf), .cwp_err(cwp_err)
    );

    // mapper 0/1: read ports, 2: write port, 3: save/restore destination
    always_comb begin
        map_idx[0] = rd_a_idx; map_cwp[0] = cwp_q;
        map_idx[1] = rd_b_idx; map_cwp[1] = cwp_q;
        map_idx[2] = wr_idx;   map_cwp[2] = cwp_q;
        map_idx[3] = op_dst;   map_cwp[3] = dest_cwp;
    end

    for (genvar m = 0; m < NMAP; m++) begin : g_map
        regwin_map #(.NWIN(NWIN), .CW(CW), .PW(PW)) u_map (
            .cwp(map_cwp[m]), .idx(map_idx[m]), .phys(map_phys[m])
        );
    end

    assign operand_b = imm_sel ? {{19{imm[12]}}, imm} : rd_b_data;
    assign sum       = rd_a_data + operand_b;

    regwin_store #(.DW(32), .DEPTH(DEPTH), .PW(PW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .ra_addr(map_phys[0]), .ra_data(rd_a_data),
        .rb_addr(map_phys[1]), .rb_data(rd_b_data),
        .wp_en(wr_en && (wr_idx != 5'd0)), .wp_addr(map_phys[2]), .wp_data(wr_data),
        .ws_en(op_go && (op_dst != 5'd0)), .ws_addr(map_phys[3]), .ws_data(sum)
    );
endmodule

// File: rtl/regwin_file_chk.sv
module regwin_file_chk #(
    parameter int NWIN = 8,
    parameter int CW   = $clog2(NWIN)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      op,
    input logic            sr_wr,
    input logic [31:0]     sr_wdata,
    input logic [CW-1:0]   cwp,
    input logic [NWIN-1:0] wim,
    input logic [4:0]      rd_a_idx,
    input logic [31:0]     rd_a_data,
    input logic            trap_ovf,
    input logic            trap_unf,
    input logic            cwp_err
);
    logic [CW-1:0] dn, up;
    logic          bad_wr;
    assign dn     = (cwp == '0) ? CW'(NWIN - 1) : cwp - CW'(1);
    assign up     = (cwp == CW'(NWIN - 1)) ? '0 : cwp + CW'(1);
    assign bad_wr = sr_wr && (sr_wdata[4:0] >= 5'(NWIN));

    assert_save_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'b01 && !sr_wr && !wim[dn]) |=> (cwp == $past(dn)));

    assert_restore_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'b10 && !sr_wr && !wim[up]) |=> (cwp == $past(up)));

    assert_ovf_trap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'b01 && !sr_wr && wim[dn]) |=> (trap_ovf && $stable(cwp)));

    assert_unf_trap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'b10 && !sr_wr && wim[up]) |=> (trap_unf && $stable(cwp)));

    assert_zero_reg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx == 5'd0) |-> (rd_a_data == 32'd0));

    assert_bad_cwp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bad_wr |=> (cwp_err && $stable(cwp)));

    assert_sr_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr && !bad_wr) |=> (cwp == $past(sr_wdata[CW-1:0]) && !trap_ovf && !trap_unf));

    assert_one_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({trap_ovf, trap_unf, cwp_err}));
endmodule

bind regwin_file regwin_file_chk #(.NWIN(NWIN)) u_chk (
    .clk(clk), .rst_n(rst_n), .op(op), .sr_wr(sr_wr), .sr_wdata(sr_wdata),
    .cwp(cwp_q), .wim(wim_q), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .trap_ovf(trap_ovf), .trap_unf(trap_unf), .cwp_err(cwp_err)
);

// File: tb/regwin_file_bench.sv
module regwin_file_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NWIN = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  rd_a_idx, rd_b_idx, wr_idx, op_dst;
    logic [31:0] rd_a_data, rd_b_data, wr_data, sr_wdata, sr_rdata, pc, npc;
    logic        wr_en, imm_sel, wim_wr, sr_wr, pc_step;
    logic [1:0]  op;
    logic [12:0] imm;
    logic [NWIN-1:0] wim_wdata;
    logic        trap_ovf, trap_unf, cwp_err;

    int checks = 0;
    int errors = 0;

    regwin_file #(.NWIN(NWIN)) u_regwin_file (
        .clk(clk), .rst_n(rst_n), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .op(op), .imm_sel(imm_sel), .imm(imm), .op_dst(op_dst),
        .wim_wr(wim_wr), .wim_wdata(wim_wdata), .sr_wr(sr_wr), .sr_wdata(sr_wdata),
        .sr_rdata(sr_rdata), .pc_step(pc_step), .pc(pc), .npc(npc),
        .trap_ovf(trap_ovf), .trap_unf(trap_unf), .cwp_err(cwp_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [4:0] idx, output logic [31:0] val);
        rd_a_idx = idx;
        #1;
        val = rd_a_data;
        rd_a_idx = 5'd0;
    endtask

    task automatic wr(input logic [4:0] idx, input logic [31:0] val);
        wr_en = 1'b1; wr_idx = idx; wr_data = val;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic winop(input logic [1:0] code, input logic [4:0] a, input logic [4:0] b,
                         input logic use_imm, input logic [12:0] iv, input logic [4:0] dst);
        op = code; rd_a_idx = a; rd_b_idx = b; imm_sel = use_imm; imm = iv; op_dst = dst;
        tick();
        op = 2'b00; rd_a_idx = 5'd0; rd_b_idx = 5'd0; imm_sel = 1'b0;
    endtask

    task automatic srw(input logic [31:0] v);
        sr_wr = 1'b1; sr_wdata = v;
        tick();
        sr_wr = 1'b0;
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        apply_reset();
        chk("R1 status after reset", sr_rdata, 32'h080);
        chk("R1 pc after reset", pc, 32'd0);
        chk("R1 npc after reset", npc, 32'd4);
        for (int i = 1; i < 8; i++) begin
            rd(5'(i), v);
            chk("R1 global cleared", v, 32'd0);
        end
        chk("R1 no flags", {29'd0, trap_ovf, trap_unf, cwp_err}, 32'd0);
    endtask

    task automatic t_map();
        logic [31:0] v;
        wr(5'd13, 32'hA0A0);
        wr(5'd5, 32'h5);
        wr(5'd20, 32'h1111);
        winop(2'b01, 5'd0, 5'd0, 1'b0, 13'd0, 5'd0);
        chk("R3 save wraps 0 to 7", sr_rdata & 32'h1F, 32'd7);
        rd(5'd29, v); chk("R2 in of new window is old out", v, 32'hA0A0);
        rd(5'd20, v); chk("R2 local is private", v, 32'd0);
        rd(5'd5, v);  chk("R2 global shared", v, 32'h5);
        winop(2'b10, 5'd0, 5'd0, 1'b0, 13'd0, 5'd0);
        chk("R4 restore wraps 7 to 0", sr_rdata & 32'h1F, 32'd0);
        rd(5'd20, v); chk("R2 local kept", v, 32'h1111);
        winop(2'b11, 5'd0, 5'd0, 1'b0, 13'd0, 5'd0);
        chk("R3 code 11 does nothing", sr_rdata & 32'h1F, 32'd0);
    endtask

    task automatic t_sum();
        logic [31:0] v;
        wr(5'd9, 32'd100);
        wr(5'd10, 32'd23);
        wr(5'd2, 32'd50);
        winop(2'b01, 5'd9, 5'd10, 1'b0, 13'd0, 5'd17);
        rd(5'd17, v); chk("R5 save register sum", v, 32'd123);
        winop(2'b01, 5'd2, 5'd0, 1'b1, 13'h1FFB, 5'd18);
        chk("R3 second save", sr_rdata & 32'h1F, 32'd6);
        rd(5'd18, v); chk("R5 save immediate sum", v, 32'd45);
        winop(2'b10, 5'd18, 5'd0, 1'b0, 13'd0, 5'd12);
        chk("R4 restore step", sr_rdata & 32'h1F, 32'd7);
        rd(5'd12, v); chk("R5 restore sum from old window", v, 32'd45);
        winop(2'b10, 5'd0, 5'd0, 1'b0, 13'd0, 5'd0);
    endtask

    task automatic t_ovf();
        logic [31:0] v;
        wim_wr = 1'b1; wim_wdata = 8'h80; tick(); wim_wr = 1'b0;
        wr(5'd3, 32'h33);
        winop(2'b01, 5'd9, 5'd10, 1'b0, 13'd0, 5'd3);
        chk("R6 overflow flag", {31'd0, trap_ovf}, 32'd1);
        chk("R6 pointer held", sr_rdata & 32'h1F, 32'd0);
        rd(5'd3, v); chk("R6 destination untouched", v, 32'h33);
        tick();
        chk("R6 flag lasts one cycle", {31'd0, trap_ovf}, 32'd0);
        wim_wr = 1'b1; wim_wdata = 8'h02; tick(); wim_wr = 1'b0;
    endtask

    task automatic t_unf();
        logic [31:0] v;
        winop(2'b10, 5'd9, 5'd10, 1'b0, 13'd0, 5'd3);
        chk("R7 underflow flag", {31'd0, trap_unf}, 32'd1);
        chk("R7 pointer held", sr_rdata & 32'h1F, 32'd0);
        rd(5'd3, v); chk("R7 destination untouched", v, 32'h33);
        tick();
        chk("R7 flag lasts one cycle", {31'd0, trap_unf}, 32'd0);
    endtask

    task automatic t_r0();
        logic [31:0] v;
        wr(5'd0, 32'hFFFF);
        rd(5'd0, v); chk("R8 write to r0 ignored", v, 32'd0);
        winop(2'b01, 5'd9, 5'd10, 1'b0, 13'd0, 5'd0);
        rd(5'd0, v); chk("R8 save into r0 ignored", v, 32'd0);
        winop(2'b10, 5'd0, 5'd0, 1'b0, 13'd0, 5'd0);
    endtask

    task automatic t_sr();
        srw(32'h905);
        chk("R9 status write/read layout", sr_rdata, 32'h905);
        srw(32'h089);
        chk("R10 error flag for 9", {31'd0, cwp_err}, 32'd1);
        chk("R10 status unchanged", sr_rdata, 32'h905);
        srw(32'h008);
        chk("R10 error flag at NWIN", {31'd0, cwp_err}, 32'd1);
        srw(32'h087);
        chk("R10 no error at NWIN-1", {31'd0, cwp_err}, 32'd0);
        chk("R9 highest legal pointer", sr_rdata, 32'h087);
    endtask

    task automatic t_conc();
        logic [31:0] v;
        sr_wr = 1'b1; sr_wdata = 32'h083;
        winop(2'b01, 5'd9, 5'd10, 1'b0, 13'd0, 5'd3);
        sr_wr = 1'b0;
        chk("R11 status write wins", sr_rdata, 32'h083);
        chk("R11 no trap", {30'd0, trap_ovf, trap_unf}, 32'd0);
        rd(5'd3, v); chk("R11 destination untouched", v, 32'h33);
        wr_en = 1'b1; wr_idx = 5'd8; wr_data = 32'hDEAD;
        winop(2'b01, 5'd2, 5'd0, 1'b1, 13'd0, 5'd24);
        wr_en = 1'b0;
        chk("R3 save to window 2", sr_rdata & 32'h1F, 32'd2);
        rd(5'd24, v); chk("R12 save value kept", v, 32'd50);
        winop(2'b10, 5'd0, 5'd0, 1'b0, 13'd0, 5'd0);
        rd(5'd8, v); chk("R12 same word seen as out", v, 32'd50);
        wr(5'd9, 32'h77);
        winop(2'b01, 5'd0, 5'd0, 1'b0, 13'd0, 5'd0);
        rd(5'd25, v); chk("R12 write port used old window", v, 32'h77);
    endtask

    task automatic t_pc();
        pc_step = 1'b1; tick(); tick(); pc_step = 1'b0;
        chk("R13 pc after two steps", pc, 32'd8);
        chk("R13 npc after two steps", npc, 32'd12);
    endtask

    initial begin
        rst_n = 1'b0; rd_a_idx = '0; rd_b_idx = '0; wr_en = 1'b0; wr_idx = '0;
        wr_data = '0; op = 2'b00; imm_sel = 1'b0; imm = '0; op_dst = '0;
        wim_wr = 1'b0; wim_wdata = '0; sr_wr = 1'b0; sr_wdata = '0; pc_step = 1'b0;
        t_reset();
        t_map();
        t_sum();
        t_ovf();
        t_unf();
        t_r0();
        t_sr();
        t_conc();
        t_pc();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule